// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between a clock synthesizer's divider outputs and the output pads. It receives the free-running waveforms of eight clock groups: CPU, 66 MHz-class, PCI, free-running PCI, CPU/2, IOAPIC, reference and USB. These waveforms are all produced in the master clock domain. From them it derives the gated copies that leave the chip. Three asynchronous active-low controls decide which groups run. CPU stop silences the CPU and 66 MHz-class groups. PCI stop silences the PCI group but not the free-running PCI output. Power-down silences everything and turns off the oscillator and PLL enables.

Stop and restart decisions are taken on rising edges of the free-running PCI source. Each group's gate can only change while that group's source is low. A stop therefore always ends after a complete high phase, and a restart always begins on a full rising edge. When power-down is released, or after reset, the oscillator and PLL enables turn on at once. A wake-up counter then keeps every output low for a parameterised number of master cycles, which gives the analog parts time to settle.

Top module: `clk_stop_ctl`

## Requirements
- R1: After reset, `osc_en` and `pll_en` are high and every output is low. The outputs stay low for `WAKE_CYCLES` master cycles, and then all eight groups toggle.
- R2: Each control input passes through a two-flop synchronizer. A CPU stop or restart is decided at the first rising edge of `pcif_src` that sees the synchronized level. If `cpu_stop_n` changes just after a `pcif_src` rise, the CPU group keeps toggling through the next `pcif_src` rise, and its state changes within two master cycles after that rise.
- R3: While `cpu_stop_n` is low, `cpu_clk` and `m66_clk` are held low. The PCI, free-running PCI, CPU/2, IOAPIC, reference and USB outputs keep toggling.
- R4: While `pci_stop_n` is low, `pci_clk` is held low. `pcif_clk` and every other group keep toggling.
- R5: A gated output rises only when its source rises and falls only when its source falls. It is never high while its source is low, so no pulse is ever shortened.
- R6: While `pwr_dn_n` is low, every output is held low. `osc_en` and `pll_en` drop only after every gate has closed.
- R7: When `pwr_dn_n` returns high, `osc_en` and `pll_en` turn on within a few cycles. All outputs stay low while `WAKE_CYCLES` master cycles elapse, and then the groups run again.
- R8: Power-down takes precedence over both stop inputs. Stop levels that are applied during power-down take effect when the block wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_stop_n | input | 1 | Async, low stops CPU and 66 MHz-class groups |
| pci_stop_n | input | 1 | Async, low stops the PCI group |
| pwr_dn_n | input | 1 | Async, low powers the block down |
| cpu_src | input | 1 | Free-running CPU waveform |
| m66_src | input | 1 | Free-running 66 MHz-class waveform |
| pci_src | input | 1 | Free-running PCI waveform |
| pcif_src | input | 1 | Free-running PCI waveform that is never stopped; it paces decisions |
| div2_src | input | 1 | Free-running CPU/2 waveform |
| apic_src | input | 1 | Free-running IOAPIC waveform |
| ref_src | input | 1 | Free-running reference waveform |
| usb_src | input | 1 | Free-running USB waveform |
| cpu_clk | output | N_CPU | Gated CPU clocks |
| m66_clk | output | N_M66 | Gated 66 MHz-class clocks |
| pci_clk | output | N_PCI | Gated PCI clocks |
| pcif_clk | output | 1 | Free-running PCI clock, gated only by power-down |
| div2_clk | output | 1 | CPU/2 clock, gated only by power-down |
| apic_clk | output | N_APIC | IOAPIC clocks, gated only by power-down |
| ref_clk | output | N_REF | Reference clocks, gated only by power-down |
| usb_clk | output | 1 | USB clock, gated only by power-down |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL/VCO enable |

## Verification
If a gate state is wrong, an output group toggles when it should be silent, or stays silent when it should toggle. This shows up within one period of the slowest source, 16 master cycles in the bench. If a gate is updated at the wrong moment, a pulse is clipped or an edge is added. That is visible at the very next source edge, because the output's edges no longer match the source's edges. A wrong decision timing or a wrong wake-count shifts the first stopped or restarted pulse by a whole PCI period or more. The bench catches this by sampling the specific master-cycle ticks around the deciding `pcif_src` edge, and the whole low window after a wake.

// File: rtl/clk_stop_ctl.sv
`timescale 1ns/1ps
module clk_stop_ctl #(
  parameter int N_CPU       = 6,
  parameter int N_M66       = 2,
  parameter int N_PCI       = 5,
  parameter int N_APIC      = 3,
  parameter int N_REF       = 2,
  parameter int WAKE_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pwr_dn_n,
  input  logic              cpu_src,
  input  logic              m66_src,
  input  logic              pci_src,
  input  logic              pcif_src,
  input  logic              div2_src,
  input  logic              apic_src,
  input  logic              ref_src,
  input  logic              usb_src,
  output logic [N_CPU-1:0]  cpu_clk,
  output logic [N_M66-1:0]  m66_clk,
  output logic [N_PCI-1:0]  pci_clk,
  output logic              pcif_clk,
  output logic              div2_clk,
  output logic [N_APIC-1:0] apic_clk,
  output logic [N_REF-1:0]  ref_clk,
  output logic              usb_clk,
  output logic              osc_en,
  output logic              pll_en
);

  localparam int NG     = 8;
  localparam int G_CPU  = 0;
  localparam int G_M66  = 1;
  localparam int G_PCI  = 2;
  localparam int G_PCIF = 3;
  localparam int G_DIV2 = 4;
  localparam int G_APIC = 5;
  localparam int G_REF  = 6;
  localparam int G_USB  = 7;
  localparam int CW     = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  typedef enum logic [1:0] {ST_WAKE, ST_RUN, ST_DRAIN, ST_OFF} pm_t;

  pm_t           state;
  logic [CW-1:0] wcnt;
  logic [1:0]    cs_q, ps_q, pd_q;
  logic          pcif_q, cpu_go, pci_go;
  logic [NG-1:0] src, want, en, gclk;
  logic          pcif_rise, run;

  assign src       = {usb_src, ref_src, apic_src, div2_src,
                      pcif_src, pci_src, m66_src, cpu_src};
  assign pcif_rise = pcif_src & ~pcif_q;
  assign run       = (state == ST_RUN);

  // input synchronizers and PCI-edge decision points
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 2'b11;
      ps_q   <= 2'b11;
      pd_q   <= 2'b11;
      pcif_q <= 1'b0;
      cpu_go <= 1'b1;
      pci_go <= 1'b1;
    end else begin
      cs_q   <= {cs_q[0], cpu_stop_n};
      ps_q   <= {ps_q[0], pci_stop_n};
      pd_q   <= {pd_q[0], pwr_dn_n};
      pcif_q <= pcif_src;
      if (pcif_rise) begin
        cpu_go <= cs_q[1];
        pci_go <= ps_q[1];
      end
    end
  end

  // power state and wake-up timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAKE;
      wcnt  <= '0;
    end else begin
      case (state)
        ST_WAKE:
          if (!pd_q[1])             state <= ST_OFF;
          else if (wcnt == WAKE_LAST) state <= ST_RUN;
          else                      wcnt  <= wcnt + 1'b1;
        ST_RUN:
          if (!pd_q[1]) state <= ST_DRAIN;
        ST_DRAIN:
          if (en == '0) state <= ST_OFF;
        default:
          if (pd_q[1]) begin
            state <= ST_WAKE;
            wcnt  <= '0;
          end
      endcase
    end
  end

  always_comb begin
    want         = {NG{run}};
    want[G_CPU]  = run & cpu_go;
    want[G_M66]  = run & cpu_go;
    want[G_PCI]  = run & pci_go;
  end

  // gates move only while their source is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else
      for (int g = 0; g < NG; g++)
        if (!src[g]) en[g] <= want[g];
  end

  assign gclk     = src & en;
  assign cpu_clk  = {N_CPU{gclk[G_CPU]}};
  assign m66_clk  = {N_M66{gclk[G_M66]}};
  assign pci_clk  = {N_PCI{gclk[G_PCI]}};
  assign pcif_clk = gclk[G_PCIF];
  assign div2_clk = gclk[G_DIV2];
  assign apic_clk = {N_APIC{gclk[G_APIC]}};
  assign ref_clk  = {N_REF{gclk[G_REF]}};
  assign usb_clk  = gclk[G_USB];
  assign osc_en   = (state != ST_OFF);
  assign pll_en   = (state != ST_OFF);

  AST_OFF_GATES_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> (en == '0)); // R6
  AST_OSC_DROP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(en) == '0)); // R6
  AST_WAKE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> (en == '0)); // R7
  AST_WAKE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt <= WAKE_LAST)); // R7
  AST_CPU_DECIDE_ON_PCIF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_go) |-> $past(pcif_rise)); // R2
  AST_PCI_DECIDE_ON_PCIF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pci_go) |-> $past(pcif_rise)); // R2
  AST_APIC_IGNORES_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src[G_APIC]) |=> en[G_APIC]); // R3
  AST_PCIF_IGNORES_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src[G_PCIF]) |=> en[G_PCIF]); // R4

  for (genvar g = 0; g < NG; g++) begin : g_edge_chk
    AST_GATE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en[g]) |-> !$past(src[g])); // R5
  end

endmodule

// File: tb/sim_clk_stop_ctl.sv
`timescale 1ns/1ps
module sim_clk_stop_ctl;
  localparam int WAKE = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
  int unsigned tick = 0;
  logic cpu_src, m66_src, pci_src, pcif_src, div2_src, apic_src, ref_src, usb_src;
  logic [5:0] cpu_clk;
  logic [1:0] m66_clk;
  logic [4:0] pci_clk;
  logic [2:0] apic_clk;
  logic [1:0] ref_clk;
  logic pcif_clk, div2_clk, usb_clk, osc_en, pll_en;
  int n_run = 0, n_fail = 0, glitches = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= tick + 1;

  assign cpu_src  = ~tick[0];
  assign m66_src  = ~tick[1];
  assign div2_src = ~tick[1];
  assign pci_src  = ~tick[2];
  assign pcif_src = ~tick[2];
  assign apic_src = ~tick[3];
  assign ref_src  = (tick % 6) < 3;
  assign usb_src  = (tick % 6) < 3;

  clk_stop_ctl #(.WAKE_CYCLES(WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_dn_n(pwr_dn_n), .cpu_src(cpu_src), .m66_src(m66_src), .pci_src(pci_src),
    .pcif_src(pcif_src), .div2_src(div2_src), .apic_src(apic_src), .ref_src(ref_src),
    .usb_src(usb_src), .cpu_clk(cpu_clk), .m66_clk(m66_clk), .pci_clk(pci_clk),
    .pcif_clk(pcif_clk), .div2_clk(div2_clk), .apic_clk(apic_clk), .ref_clk(ref_clk),
    .usb_clk(usb_clk), .osc_en(osc_en), .pll_en(pll_en));

  wire [7:0] obs  = {usb_clk, |ref_clk, |apic_clk, div2_clk, pcif_clk, |pci_clk, |m66_clk, |cpu_clk};
  wire [7:0] srcv = {usb_src, ref_src, apic_src, div2_src, pcif_src, pci_src, m66_src, cpu_src};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  typedef struct { string rq; logic [7:0] mask; } item_t;
  item_t q[$];
  bit busy = 1'b0;

  initial forever begin
    item_t it;
    logic [7:0] seen;
    wait (q.size() > 0);
    busy = 1'b1;
    it = q.pop_front();
    seen = '0;
    repeat (40) begin @(posedge clk); #1; seen |= obs; end
    chk(it.rq, {24'd0, seen}, {24'd0, it.mask});
    busy = 1'b0;
  end

  task automatic expect_mask(input string rq, input logic [7:0] m);
    item_t it;
    it.rq = rq; it.mask = m;
    q.push_back(it);
    wait (q.size() == 0);
    wait (!busy);
  endtask

  // R5 edge-alignment monitor
  initial begin
    logic [7:0] po, ps;
    po = '0; ps = '0;
    forever begin
      @(clk); #1;
      if (rst_n) begin
        for (int g = 0; g < 8; g++) begin
          if (obs[g] && !srcv[g]) glitches++;
          if (obs[g] && !po[g] && !(srcv[g] && !ps[g])) glitches++;
          if (!obs[g] && po[g] && !(!srcv[g] && ps[g])) glitches++;
        end
      end
      po = obs; ps = srcv;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic to_pcif_rise();
    do begin @(negedge clk); #1; end while (tick % 8 != 0);
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic any;
    idle(5);
    chk("R1 outputs in reset", {24'd0, obs}, 32'd0);
    #0 rst_n = 1'b1;
    idle(3);
    chk("R1 low during wake", {24'd0, obs}, 32'd0);
    chk("R1 osc/pll on", {30'd0, osc_en, pll_en}, 32'd3);
    idle(60);
    expect_mask("R1 all run after wake", 8'hFF);

    cpu_stop_n = 1'b0; idle(20);
    expect_mask("R3 cpu stop", 8'hFC);
    cpu_stop_n = 1'b1; idle(20);
    expect_mask("R3 cpu resume", 8'hFF);

    to_pcif_rise(); cpu_stop_n = 1'b0;
    any = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      idle(1);
      if (k == 8) chk("R2 cpu still running at deciding edge", {26'd0, cpu_clk}, 32'h3F);
      if (k >= 10 && |cpu_clk) any = 1'b1;
    end
    chk("R2 cpu stopped after deciding edge", {31'd0, any}, 32'd0);

    to_pcif_rise(); cpu_stop_n = 1'b1;
    any = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      idle(1);
      if (k <= 9 && |cpu_clk) any = 1'b1;
      if (k == 10) chk("R2 cpu restarts after deciding edge", {26'd0, cpu_clk}, 32'h3F);
    end
    chk("R2 cpu silent before deciding edge", {31'd0, any}, 32'd0);
    idle(20);

    pci_stop_n = 1'b0; idle(20);
    expect_mask("R4 pci stop keeps free pci", 8'hFB);
    cpu_stop_n = 1'b0; idle(20);
    expect_mask("R4 both stops", 8'hF8);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; idle(20);
    expect_mask("R4 both resume", 8'hFF);

    pwr_dn_n = 1'b0; idle(30);
    chk("R6 osc/pll off", {30'd0, osc_en, pll_en}, 32'd0);
    expect_mask("R6 all low", 8'h00);

    pwr_dn_n = 1'b1;
    any = 1'b0;
    for (int k = 1; k <= 48; k++) begin
      idle(1);
      if (|obs) any = 1'b1;
      if (k == 5) chk("R7 osc/pll back on", {30'd0, osc_en, pll_en}, 32'd3);
    end
    chk("R7 outputs low while waking", {31'd0, any}, 32'd0);
    idle(20);
    expect_mask("R7 run after wake", 8'hFF);

    pwr_dn_n = 1'b0; idle(30);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; idle(20);
    expect_mask("R8 power-down wins", 8'h00);
    pwr_dn_n = 1'b1; idle(70);
    expect_mask("R8 stops applied on wake", 8'hF8);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; idle(20);
    expect_mask("R8 resume", 8'hFF);

    chk("R5 edge alignment violations", glitches, 32'd0);
    finish_run();
  end
endmodule